// File: doc/BRIEF.md
# Processor Bus Bridge to Video RAM and Control Registers

This block connects a microprocessor bus to an internal video RAM and to a small bank of control registers. The processor may be 8 bits or 16 bits wide. A static mode input selects the width, and the width decides how the address and the byte lanes map onto the RAM words. The bus has two active-low chip selects. One opens the register bank and is meant for I/O space. The other opens the video RAM and is meant for memory space. An access is made with an active-low read strobe, a low-write strobe or a high-write strobe.

A display refresh engine outside this block reads the RAM by cycle stealing. It raises a fetch request, waits for the grant, and then reads words through its own port. A processor RAM access that arrives while a fetch holds the RAM is kept pending. The block pulls an active-low wait output low for as long as that access is pending. When the fetch ends, the block carries out the pending access and releases wait on the next rising edge of the processor clock. Register accesses never wait.

Top module: `hbi_top`

## Requirements
- R1: With `reg_cs_n` low, a low on `lwr_n` stores `dq_in[7:0]` into the register selected by `addr[4:0]`. With `reg_cs_n` and `rd_n` low, `dq_out` returns `{8'h00, register}`. Every register is also visible on `cfg_q`, with register k in bits `8k+7:8k`.
- R2: While `rst_n` is low, all registers clear to zero, `fetch_gnt` is low and `wait_n` is high.
- R3: In 8-bit mode (`wide16`=0), RAM byte address `addr` selects word `addr[ADDR_W-1:1]`. If `addr[0]`=0 the access uses the low byte of that word; if `addr[0]`=1 it uses the high byte. A read returns the byte on `dq_out[7:0]` with `dq_out[15:8]` at zero.
- R4: In 8-bit mode, `hwr_n`, `bhe_n` and `dq_in[15:8]` have no effect on what a write stores.
- R5: In 16-bit mode with `addr[0]`=0 and `bhe_n` high, `lwr_n` writes `dq_in[7:0]` into the low byte of word `addr[ADDR_W-1:1]`, and `hwr_n` writes `dq_in[15:8]` into its high byte.
- R6: In 16-bit mode using `lwr_n` alone, the lanes are chosen as follows: `addr[0]`=0 with `bhe_n`=0 writes both bytes; `addr[0]`=0 with `bhe_n`=1 writes only the low byte; `addr[0]`=1 with `bhe_n`=0 writes only the high byte, taken from `dq_in[15:8]`.
- R7: `dq_oe` is high exactly when `rd_n` is low and one of the chip selects is low. When `dq_oe` is low, `dq_out` is zero.
- R8: `fetch_gnt` rises one cycle after `fetch_req` rises, provided no host RAM access is pending. It stays high while `fetch_req` stays high and falls one cycle after `fetch_req` falls. `fetch_data` shows the RAM word at `fetch_addr`.
- R9: `wait_n` goes low, with no clock edge needed, when an unserved host RAM access (memory chip select plus any strobe) overlaps a granted fetch. The RAM is never written while `fetch_gnt` is high.
- R10: A held access stays unperformed while the grant lasts. The first rising edge after `fetch_gnt` falls performs it, and `wait_n` returns high at that edge.
- R11: A host RAM access that is pending in the same cycle that `fetch_req` rises is served first. The grant then follows one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low reset |
| wide16 | input | 1 | Bus width: 1 = 16-bit, 0 = 8-bit (static) |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 16 | Write data from the processor |
| dq_out | output | 16 | Read data to the processor |
| dq_oe | output | 1 | Enable for the read data drivers |
| reg_cs_n | input | 1 | Register bank select, active low |
| mem_cs_n | input | 1 | Video RAM select, active low |
| rd_n | input | 1 | Read strobe, active low |
| lwr_n | input | 1 | Low-byte / register write strobe, active low |
| hwr_n | input | 1 | High-byte write strobe (16-bit mode), active low |
| bhe_n | input | 1 | Upper byte enable, active low |
| wait_n | output | 1 | Wait request to the processor, active low |
| fetch_req | input | 1 | Cycle-steal request from the display engine |
| fetch_gnt | output | 1 | Grant of the RAM to the display engine |
| fetch_addr | input | ADDR_W-1 | Word address of the display fetch |
| fetch_data | output | 16 | RAM word at `fetch_addr` |
| cfg_q | output | NREG*8 | All control registers, flattened |

## Verification
The assertions assume that the two chip selects are never low together, that the mode input changes only while the bus is idle, and that a processor holds its strobes until `wait_n` is high. The write strobes must also go high between two writes, because a held access is served only once. The bench drives every input on the falling clock edge. It returns all strobes to idle between tasks, keeps the two selects mutually exclusive, and changes `wide16` only with the bus idle. Waited accesses keep their strobes low until the bench has seen `wait_n` return high.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

  typedef struct packed {
    logic hi;
    logic lo;
  } lanes_t;

  // 16-bit mode: a separate high strobe, or lwr_n qualified by A0 / bhe_n
  function automatic lanes_t lanes_wide(input logic a0, input logic bhe_n,
                                        input logic lwr_n, input logic hwr_n);
    lanes_t l;
    l.lo = !lwr_n && !a0;
    l.hi = !hwr_n || (!lwr_n && !bhe_n);
    return l;
  endfunction

  // 8-bit mode: A0 alone picks the byte, only lwr_n writes
  function automatic lanes_t lanes_narrow(input logic a0, input logic lwr_n);
    lanes_t l;
    l.lo = !lwr_n && !a0;
    l.hi = !lwr_n && a0;
    return l;
  endfunction

  // Byte extraction for 8-bit reads
  function automatic logic [15:0] narrow_read(input logic [15:0] word, input logic a0);
    return {8'h00, (a0 ? word[15:8] : word[7:0])};
  endfunction

endpackage

// File: rtl/hbi_arb.sv
module hbi_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic host_acc,   // memory select with any strobe
  input  logic fetch_req,
  output logic fetch_gnt,
  output logic host_go,    // cycle in which the host access is performed
  output logic wait_n
);

  logic gnt_q, hold_q, served_q;
  logic pend;

  assign pend    = host_acc && !served_q;
  assign host_go = pend && !gnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q    <= 1'b0;
      hold_q   <= 1'b0;
      served_q <= 1'b0;
    end else begin
      gnt_q    <= fetch_req && (gnt_q || !pend);
      hold_q   <= pend && gnt_q;
      served_q <= host_acc && (served_q || host_go);
    end
  end

  assign fetch_gnt = gnt_q;
  assign wait_n    = !(pend && (gnt_q || hold_q));

  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_gnt) |=> fetch_gnt); // R8
  AST_GNT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_req |=> !fetch_gnt); // R8
  AST_WAIT_REL: assert property (@(posedge clk) disable iff (!rst_n)
    (host_acc && $rose(wait_n)) |-> served_q); // R10
  AST_HOST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_gnt) |-> $past(!pend)); // R11

endmodule

// File: rtl/hbi_vram.sv
module hbi_vram #(
  parameter int WORD_AW = 9
) (
  input  logic               clk,
  input  logic [WORD_AW-1:0] wr_addr,
  input  logic [1:0]         wr_be,     // {hi, lo}
  input  logic [15:0]        wr_data,
  output logic [15:0]        host_rdata,
  input  logic [WORD_AW-1:0] fetch_addr,
  output logic [15:0]        fetch_rdata
);

  localparam int WORDS = 1 << WORD_AW;

  logic [15:0] mem [WORDS];

  for (genvar b = 0; b < 2; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (wr_be[b]) mem[wr_addr][8*b +: 8] <= wr_data[8*b +: 8];
    end
  end

  assign host_rdata  = mem[wr_addr];
  assign fetch_rdata = mem[fetch_addr];

endmodule

// File: rtl/hbi_regs.sv
module hbi_regs #(
  parameter int NREG = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] sel,
  input  logic [7:0]              wdata,
  output logic [7:0]              rdata,
  output logic [NREG*8-1:0]       cfg_q
);

  logic [7:0] r [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         r[k] <= 8'h00;
      else if (we && (32'(sel) == k))     r[k] <= wdata;
    end
    assign cfg_q[8*k +: 8] = r[k];
  end

  assign rdata = r[sel];

endmodule

// File: rtl/hbi_top.sv
module hbi_top #(
  parameter int ADDR_W = 10,
  parameter int NREG   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wide16,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [15:0]         dq_in,
  output logic [15:0]         dq_out,
  output logic                dq_oe,
  input  logic                reg_cs_n,
  input  logic                mem_cs_n,
  input  logic                rd_n,
  input  logic                lwr_n,
  input  logic                hwr_n,
  input  logic                bhe_n,
  output logic                wait_n,
  input  logic                fetch_req,
  output logic                fetch_gnt,
  input  logic [ADDR_W-2:0]   fetch_addr,
  output logic [15:0]         fetch_data,
  output logic [NREG*8-1:0]   cfg_q
);
  import hbi_pkg::*;

  localparam int WORD_AW = ADDR_W - 1;
  localparam int RSEL_W  = $clog2(NREG);

  logic              strobe, host_acc, host_go;
  lanes_t            lanes;
  logic [1:0]        ram_we;
  logic [15:0]       ram_wdata, ram_rdata, rd_mux;
  logic [7:0]        reg_rdata;

  assign strobe   = !rd_n || !lwr_n || (wide16 && !hwr_n);
  assign host_acc = !mem_cs_n && strobe;

  assign lanes     = wide16 ? lanes_wide(addr[0], bhe_n, lwr_n, hwr_n)
                            : lanes_narrow(addr[0], lwr_n);
  assign ram_we    = {2{host_go && !mem_cs_n}} & {lanes.hi, lanes.lo};
  assign ram_wdata = wide16 ? dq_in : {dq_in[7:0], dq_in[7:0]};

  hbi_arb u_arb (
    .clk(clk), .rst_n(rst_n), .host_acc(host_acc), .fetch_req(fetch_req),
    .fetch_gnt(fetch_gnt), .host_go(host_go), .wait_n(wait_n)
  );

  hbi_vram #(.WORD_AW(WORD_AW)) u_vram (
    .clk(clk), .wr_addr(addr[ADDR_W-1:1]), .wr_be(ram_we), .wr_data(ram_wdata),
    .host_rdata(ram_rdata), .fetch_addr(fetch_addr), .fetch_rdata(fetch_data)
  );

  hbi_regs #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(!reg_cs_n && !lwr_n), .sel(addr[RSEL_W-1:0]),
    .wdata(dq_in[7:0]), .rdata(reg_rdata), .cfg_q(cfg_q)
  );

  always_comb begin
    if (!reg_cs_n)   rd_mux = {8'h00, reg_rdata};
    else if (wide16) rd_mux = ram_rdata;
    else             rd_mux = narrow_read(ram_rdata, addr[0]);
  end

  assign dq_oe  = !rd_n && (!reg_cs_n || !mem_cs_n);
  assign dq_out = dq_oe ? rd_mux : 16'h0000;

  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide16 && dq_oe) |-> (dq_out[15:8] == 8'h00)); // R3
  AST_NO_WRITE_IN_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (|ram_we) |-> !fetch_gnt); // R9
  AST_WAIT_ONLY_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_n |-> !mem_cs_n); // R9
  AST_OE_NEEDS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !rd_n); // R7

endmodule

// File: tb/sim_hbi_top.sv
`timescale 1ns/1ps
module sim_hbi_top;
  localparam int AW = 10;
  localparam int NR = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, wide16, reg_cs_n, mem_cs_n, rd_n, lwr_n, hwr_n, bhe_n, fetch_req;
  logic [AW-1:0] addr;
  logic [15:0] dq_in, dq_out, fetch_data;
  logic dq_oe, wait_n, fetch_gnt;
  logic [AW-2:0] fetch_addr;
  logic [NR*8-1:0] cfg_q;

  int checks = 0, fails = 0;
  bit done = 0;

  hbi_top #(.ADDR_W(AW), .NREG(NR)) u0 (
    .clk(clk), .rst_n(rst_n), .wide16(wide16), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .reg_cs_n(reg_cs_n), .mem_cs_n(mem_cs_n),
    .rd_n(rd_n), .lwr_n(lwr_n), .hwr_n(hwr_n), .bhe_n(bhe_n), .wait_n(wait_n),
    .fetch_req(fetch_req), .fetch_gnt(fetch_gnt), .fetch_addr(fetch_addr),
    .fetch_data(fetch_data), .cfg_q(cfg_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    reg_cs_n = 1; mem_cs_n = 1; rd_n = 1; lwr_n = 1; hwr_n = 1; bhe_n = 1;
    addr = '0; dq_in = '0;
  endtask

  // one write cycle; strobes set at negedge, held across one posedge
  task automatic wr(input logic mem, input logic [AW-1:0] a, input logic [15:0] d,
                    input logic lw, input logic hw, input logic bh);
    @(negedge clk);
    addr = a; dq_in = d; lwr_n = lw; hwr_n = hw; bhe_n = bh;
    if (mem) mem_cs_n = 0; else reg_cs_n = 0;
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input logic mem, input logic [AW-1:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a; rd_n = 0;
    if (mem) mem_cs_n = 0; else reg_cs_n = 0;
    #1 d = dq_out;
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    logic [15:0] d;
    #1;
    chk("R2 wait_n", 32'(wait_n), 1);
    chk("R2 fetch_gnt", 32'(fetch_gnt), 0);
    chk("R2 cfg_q zero", 32'(|cfg_q), 0);
    rd(0, 10'd3, d);
    chk("R2 reg3 read", 32'(d), 0);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    wr(0, 10'd5, 16'hFFA5, 0, 1, 1);
    wr(0, 10'd31, 16'h003C, 0, 1, 1);
    rd(0, 10'd5, d);   chk("R1 reg5", 32'(d), 32'h00A5);
    rd(0, 10'd31, d);  chk("R1 reg31", 32'(d), 32'h003C);
    chk("R1 cfg_q reg5", 32'(cfg_q[5*8 +: 8]), 32'hA5);
  endtask

  task automatic t_oe();
    @(negedge clk); #1;
    chk("R7 oe idle", 32'(dq_oe), 0);
    chk("R7 out idle", 32'(dq_out), 0);
    rd_n = 0; #1;
    chk("R7 oe no cs", 32'(dq_oe), 0);
    reg_cs_n = 0; addr = 10'd5; #1;
    chk("R7 oe reg rd", 32'(dq_oe), 1);
    rd_n = 1; lwr_n = 1; #1;
    chk("R7 oe cs only", 32'(dq_oe), 0);
    idle();
  endtask

  task automatic t_narrow();
    logic [15:0] d;
    wide16 = 0;
    wr(1, 10'd6, 16'hFF11, 0, 0, 0);
    wr(1, 10'd7, 16'hEE22, 0, 0, 0);
    // hwr_n alone in 8-bit mode must store nothing
    wr(1, 10'd6, 16'h9999, 1, 0, 0);
    rd(1, 10'd6, d); chk("R3 R4 byte6", 32'(d), 32'h0011);
    rd(1, 10'd7, d); chk("R3 byte7", 32'(d), 32'h0022);
    wide16 = 1;
    rd(1, 10'd6, d); chk("R3 word view", 32'(d), 32'h2211);
  endtask

  task automatic t_strobe16();
    logic [15:0] d;
    wide16 = 1;
    wr(1, 10'd8, 16'hBEEF, 0, 1, 1);
    rd(1, 10'd8, d); chk("R5 low only", 32'(d[7:0]), 32'hEF);
    wr(1, 10'd8, 16'h1234, 1, 0, 1);
    rd(1, 10'd8, d); chk("R5 high strobe", 32'(d), 32'h12EF);
  endtask

  task automatic t_bhe16();
    logic [15:0] d;
    wide16 = 1;
    wr(1, 10'd10, 16'hCAFE, 0, 1, 0);
    rd(1, 10'd10, d); chk("R6 both lanes", 32'(d), 32'hCAFE);
    wr(1, 10'd11, 16'h5500, 0, 1, 0);
    rd(1, 10'd10, d); chk("R6 high via A0", 32'(d), 32'h55FE);
    wr(1, 10'd10, 16'h0077, 0, 1, 1);
    rd(1, 10'd10, d); chk("R6 low only", 32'(d), 32'h5577);
  endtask

  task automatic t_steal();
    logic [15:0] d;
    wide16 = 1;
    wr(1, 10'd20, 16'h0101, 0, 1, 0);
    fetch_addr = 9'd10;
    @(negedge clk); fetch_req = 1; #1;
    chk("R8 gnt not yet", 32'(fetch_gnt), 0);
    @(negedge clk); #1;
    chk("R8 gnt rises", 32'(fetch_gnt), 1);
    // register access during grant never waits
    reg_cs_n = 0; lwr_n = 0; addr = 10'd2; dq_in = 16'h0044; #1;
    chk("R9 reg no wait", 32'(wait_n), 1);
    @(negedge clk); idle();
    addr = 10'd20; dq_in = 16'h4242; lwr_n = 0; bhe_n = 0; mem_cs_n = 0; #1;
    chk("R9 wait low", 32'(wait_n), 0);
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R9 still waiting", 32'(wait_n), 0);
    chk("R8 fetch_data old", 32'(fetch_data), 32'h0101);
    fetch_req = 0;
    @(negedge clk); #1;
    chk("R8 gnt drops", 32'(fetch_gnt), 0);
    chk("R10 wait held", 32'(wait_n), 0);
    @(negedge clk); #1;
    chk("R10 wait released", 32'(wait_n), 1);
    chk("R10 write landed", 32'(fetch_data), 32'h4242);
    idle();
    rd(1, 10'd20, d); chk("R10 readback", 32'(d), 32'h4242);
    chk("R1 reg2 in grant", 32'(cfg_q[2*8 +: 8]), 32'h44);
  endtask

  task automatic t_prio();
    logic [15:0] d;
    wide16 = 1;
    fetch_addr = 9'd15;
    @(negedge clk);
    addr = 10'd30; dq_in = 16'h7777; lwr_n = 0; bhe_n = 0; mem_cs_n = 0;
    fetch_req = 1; #1;
    chk("R11 no wait", 32'(wait_n), 1);
    @(negedge clk); #1;
    chk("R11 gnt deferred", 32'(fetch_gnt), 0);
    chk("R11 written", 32'(fetch_data), 32'h7777);
    @(negedge clk); #1;
    chk("R11 gnt follows", 32'(fetch_gnt), 1);
    idle(); fetch_req = 0;
    @(negedge clk); #1;
    chk("R8 gnt off", 32'(fetch_gnt), 0);
    rd(1, 10'd30, d); chk("R11 readback", 32'(d), 32'h7777);
  endtask

  initial begin
    idle(); wide16 = 1; fetch_req = 0; fetch_addr = '0; rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_regs();
    t_oe();
    t_narrow();
    t_strobe16();
    t_bhe16();
    t_steal();
    t_prio();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule